// File: doc/BRIEF.md
# Store Drain Queue

This block holds stores from the processor pipeline so that a load can proceed while earlier stores wait their turn. Every store goes into one shared ring of entries. Each entry carries a destination code that selects one of three memories: the data cache, the local data RAM, or the external local-memory port. The oldest entry is offered to its destination through a valid/ready handshake. It is offered only in a cycle when that destination is not serving a load. It retires in the cycle the destination accepts it.

A load presents its address and byte mask. The block searches the buffered stores for the same word. When it finds one, it merges the newest matching store's bytes into the data returned by memory. When that store does not supply every byte the load asks for, the block raises a wait signal, and the load must retry after the store has drained. A flush request blocks new stores until the ring is empty.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the ring is empty: `sb_empty` is 1, `sb_full` is 0, `st_stall` is 0 and no `dr_valid` bit is set. `dr_valid` is all zero whenever the ring is empty.
- R2: A store is accepted in a cycle where `st_valid` is 1 and `st_stall` is 0. Once 4 entries are held, `sb_full` and `st_stall` are 1, and a store offered while stalled is dropped and never drained.
- R3: Stores leave in the order they were accepted. Only the oldest entry is offered, on `dr_addr`, `dr_data` and `dr_be`, and a younger entry waits even when its own destination is free.
- R4: The destination code selects one `dr_valid` bit: 00 selects bit 0 (data cache), 01 selects bit 1 (data RAM) and 10 selects bit 2 (local-memory port). Code 11 is never supplied, and at most one bit is set.
- R5: `dr_valid[t]` stays 0 in every cycle where `tgt_busy[t]` is 1. A load always wins the port, and the head entry waits.
- R6: The head entry retires at the clock edge where its `dr_valid` bit and the matching `dr_ready` bit are both 1. The next entry is offered from the following cycle. Each cycle retires at most one entry.
- R7: When `ld_valid` is 1 and a buffered store has the same word address (bits 31:2), `ld_hit` is 1. `ld_result` then takes from the newest such store each byte that store enables, and takes every other byte from `ld_mem_data`. With no match, `ld_hit` is 0 and `ld_result` equals `ld_mem_data`.
- R8: `ld_wait` is 1 exactly when `ld_hit` is 1 and the newest matching store's byte enables do not include every bit set in `ld_be`.
- R9: A one-cycle `flush` pulse keeps `st_stall` at 1 until the ring is empty, even when it is not full. `st_stall` drops in the cycle `sb_empty` rises.
- R10: While the head entry does not retire, `dr_addr`, `dr_data` and `dr_be` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Pipeline offers a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_tgt | input | 2 | Destination code (00 cache, 01 data RAM, 10 local-memory port) |
| st_stall | output | 1 | Store not accepted this cycle |
| flush | input | 1 | Request to block stores until the ring drains |
| sb_empty | output | 1 | No entries held |
| sb_full | output | 1 | All entries held |
| tgt_busy | input | 3 | Per-destination flag: port is serving a load |
| dr_valid | output | 3 | Per-destination drain request for the head entry |
| dr_ready | input | 3 | Per-destination accept |
| dr_addr | output | 32 | Head entry address |
| dr_data | output | 32 | Head entry data |
| dr_be | output | 4 | Head entry byte enables |
| ld_valid | input | 1 | A load is looking up the ring |
| ld_addr | input | 32 | Load byte address |
| ld_be | input | 4 | Bytes the load needs |
| ld_mem_data | input | 32 | Data read from memory for the load |
| ld_hit | output | 1 | A buffered store matches the load word |
| ld_wait | output | 1 | The match does not cover the load; retry later |
| ld_result | output | 32 | Memory data with buffered bytes merged in |

## Verification
The properties assume the pipeline never supplies destination code 11. They also assume that `tgt_busy` and `dr_ready` are plain per-port levels with no further protocol tied to them. The stimulus uses only codes 00, 01 and 10. It changes every input shortly after a rising edge and samples on the falling edge, so no check sees an input mid-change. During the mixed phase, the ready and busy levels come from a pseudo-random generator that lets every port make progress, so the ring always empties. Stores offered while the stall is raised are held for several cycles. Those stores never reach the scoreboard, so any stray retire shows up as an unexpected drain.

// File: rtl/stq_pkg.sv
package stq_pkg;
  parameter int unsigned AW   = 32;
  parameter int unsigned DW   = 32;
  parameter int unsigned NTGT = 3;
  localparam int unsigned BW   = DW / 8;
  localparam int unsigned TW   = $clog2(NTGT + 1);
  localparam int unsigned OFFW = $clog2(BW);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [BW-1:0] be;
    logic [TW-1:0] tgt;
  } stq_ent_t;

  // Same word when all address bits above the byte offset agree
  function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:OFFW] == b[AW-1:OFFW];
  endfunction

  // Bytes enabled in be come from upd, the rest from base
  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] base,
                                                input logic [DW-1:0] upd,
                                                input logic [BW-1:0] be);
    logic [DW-1:0] r;
    r = base;
    for (int b = 0; b < int'(BW); b++)
      if (be[b]) r[b*8 +: 8] = upd[b*8 +: 8];
    return r;
  endfunction

  function automatic logic covers(input logic [BW-1:0] have, input logic [BW-1:0] need);
    return (have & need) == need;
  endfunction

  function automatic logic [NTGT-1:0] tgt_onehot(input logic [TW-1:0] code);
    return NTGT'(1) << code;
  endfunction
endpackage

// File: rtl/stq_ring.sv
module stq_ring
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  stq_ent_t         push_ent,
  output stq_ent_t         ent_q [DEPTH],
  output logic [PW-1:0]    head_q,
  output logic [CW-1:0]    occ_q
);
  logic [PW-1:0] tail_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) ent_q[tail_q] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push) tail_q <= step(tail_q);
      if (pop)  head_q <= step(head_q);
      occ_q <= occ_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] e_addr [DEPTH],
  input  logic [DW-1:0] e_data [DEPTH],
  input  logic [BW-1:0] e_be   [DEPTH],
  input  logic [PW-1:0] head_q,
  input  logic [CW-1:0] occ_q,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  input  logic [DW-1:0] ld_mem_data,
  output logic          ld_hit,
  output logic          ld_wait,
  output logic [DW-1:0] ld_result
);
  logic          found;
  logic [DW-1:0] best_data;
  logic [BW-1:0] best_be;
  logic [PW-1:0] idx;

  // Walk oldest to newest so the last match seen is the newest
  always_comb begin
    found     = 1'b0;
    best_data = '0;
    best_be   = '0;
    idx       = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      idx = PW'((int'(head_q) + i) % int'(DEPTH));
      if (i < int'(occ_q) && same_word(e_addr[idx], ld_addr)) begin
        found     = 1'b1;
        best_data = e_data[idx];
        best_be   = e_be[idx];
      end
    end
  end

  assign ld_hit    = ld_valid && found;
  assign ld_wait   = ld_hit && !covers(best_be, ld_be);
  assign ld_result = ld_hit ? merge_bytes(ld_mem_data, best_data, best_be) : ld_mem_data;
endmodule

// File: rtl/store_drain_queue.sv
module store_drain_queue
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [BW-1:0]   st_be,
  input  logic [TW-1:0]   st_tgt,
  output logic            st_stall,
  input  logic            flush,
  output logic            sb_empty,
  output logic            sb_full,
  input  logic [NTGT-1:0] tgt_busy,
  output logic [NTGT-1:0] dr_valid,
  input  logic [NTGT-1:0] dr_ready,
  output logic [AW-1:0]   dr_addr,
  output logic [DW-1:0]   dr_data,
  output logic [BW-1:0]   dr_be,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [BW-1:0]   ld_be,
  input  logic [DW-1:0]   ld_mem_data,
  output logic            ld_hit,
  output logic            ld_wait,
  output logic [DW-1:0]   ld_result
);
  stq_ent_t      ent_q [DEPTH];
  stq_ent_t      new_ent;
  stq_ent_t      head_ent;
  logic [PW-1:0] head_q;
  logic [CW-1:0] occ;
  logic          push_fire;
  logic          pop_fire;
  logic          flush_hold_q;
  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [BW-1:0] e_be   [DEPTH];

  assign new_ent   = '{addr: st_addr, data: st_data, be: st_be, tgt: st_tgt};
  assign sb_empty  = (occ == '0);
  assign sb_full   = (occ == CW'(DEPTH));
  assign st_stall  = sb_full || ((flush || flush_hold_q) && !sb_empty);
  assign push_fire = st_valid && !st_stall;

  always_ff @(posedge clk) begin
    if (!rst_n) flush_hold_q <= 1'b0;
    else        flush_hold_q <= (flush_hold_q || flush) && !sb_empty;
  end

  stq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_fire),
    .pop      (pop_fire),
    .push_ent (new_ent),
    .ent_q    (ent_q),
    .head_q   (head_q),
    .occ_q    (occ)
  );

  // Drain side: only the head is offered, and a busy port masks it
  assign head_ent = ent_q[head_q];
  assign dr_addr  = head_ent.addr;
  assign dr_data  = head_ent.data;
  assign dr_be    = head_ent.be;
  assign dr_valid = sb_empty ? '0 : (tgt_onehot(head_ent.tgt) & ~tgt_busy);
  assign pop_fire = |(dr_valid & dr_ready);

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_split
    assign e_addr[g] = ent_q[g].addr;
    assign e_data[g] = ent_q[g].data;
    assign e_be[g]   = ent_q[g].be;
  end

  stq_fwd #(.DEPTH(DEPTH)) u_fwd (
    .e_addr      (e_addr),
    .e_data      (e_data),
    .e_be        (e_be),
    .head_q      (head_q),
    .occ_q       (occ),
    .ld_valid    (ld_valid),
    .ld_addr     (ld_addr),
    .ld_be       (ld_be),
    .ld_mem_data (ld_mem_data),
    .ld_hit      (ld_hit),
    .ld_wait     (ld_wait),
    .ld_result   (ld_result)
  );
endmodule

// File: rtl/stq_chk.sv
module stq_chk
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TW-1:0]   st_tgt,
  input logic            push_fire,
  input logic            pop_fire,
  input logic [CW-1:0]   occ,
  input logic            sb_full,
  input logic            sb_empty,
  input logic            st_stall,
  input logic            flush,
  input logic [NTGT-1:0] dr_valid,
  input logic [NTGT-1:0] tgt_busy,
  input logic [AW-1:0]   dr_addr,
  input logic [DW-1:0]   dr_data,
  input logic            ld_hit,
  input logic            ld_wait
);
  // R1
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> dr_valid == '0);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_full |-> !push_fire);
  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> st_tgt != TW'(3));
  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dr_valid));
  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid & tgt_busy) == '0);
  // R6
  grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !pop_fire) |=> occ == $past(occ) + CW'(1));
  // R6
  shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire) |=> occ == $past(occ) - CW'(1));
  // R8
  wait_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wait |-> ld_hit);
  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !sb_empty) |-> st_stall);
  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_fire && !sb_empty) |=> $stable(dr_addr) && $stable(dr_data));
endmodule

bind store_drain_queue stq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_tgt    (st_tgt),
  .push_fire (push_fire),
  .pop_fire  (pop_fire),
  .occ       (occ),
  .sb_full   (sb_full),
  .sb_empty  (sb_empty),
  .st_stall  (st_stall),
  .flush     (flush),
  .dr_valid  (dr_valid),
  .tgt_busy  (tgt_busy),
  .dr_addr   (dr_addr),
  .dr_data   (dr_data),
  .ld_hit    (ld_hit),
  .ld_wait   (ld_wait)
);

// File: tb/store_drain_queue_test.sv
`timescale 1ns/1ps
module store_drain_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic [1:0]  st_tgt = '0;
  logic        st_stall, flush = 1'b0, sb_empty, sb_full;
  logic [2:0]  tgt_busy = '0, dr_valid, dr_ready = '0;
  logic [31:0] dr_addr, dr_data;
  logic [3:0]  dr_be;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0, ld_mem_data = '0;
  logic [3:0]  ld_be = '0;
  logic        ld_hit, ld_wait;
  logic [31:0] ld_result;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [1:0]  tgt;
  } item_t;
  item_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  int rdy_mode = 0, bsy_mode = 0;
  logic [2:0]  bsy_val = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #5 clk = ~clk;

  store_drain_queue uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Port-level ready/busy stimulus, changed just after each edge
  always begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: dr_ready = 3'b000;
      1: dr_ready = 3'b111;
      default: dr_ready = lfsr[2:0] | lfsr[8:6];
    endcase
    tgt_busy = (bsy_mode == 0) ? bsy_val : (lfsr[5:3] & lfsr[11:9]);
  end

  // Monitor: each retire is compared against the oldest expected store
  always @(negedge clk) begin
    if (rst_n) begin
      // R5: a busy port never sees a drain request
      if ((dr_valid & tgt_busy) != 0) chk(0, "R5 busy port requested", {29'b0, dr_valid}, 32'h0);
      if ((dr_valid & dr_ready) != 0) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected drain", dr_addr, 32'h0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          chk(dr_addr == e.addr, "R3 order addr", dr_addr, e.addr);
          chk(dr_data == e.data, "R3 order data", dr_data, e.data);
          chk(dr_be == e.be, "R3 order be", {28'b0, dr_be}, {28'b0, e.be});
          chk(dr_valid == (3'b001 << e.tgt), "R4 port select", {29'b0, dr_valid}, {29'b0, 3'b001 << e.tgt});
        end
      end
    end
  end

  // Driver: offer a store, record it once it is accepted
  task automatic push_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b, input logic [1:0] t);
    item_t e;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = b; st_tgt = t;
    do @(negedge clk); while (st_stall);
    e.addr = a; e.data = d; e.be = b; e.tgt = t;
    exp_q.push_back(e);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_empty(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!sb_empty && n < 2000);
    chk(sb_empty == 1'b1, req, {31'b0, sb_empty}, 32'h1);
    @(posedge clk); #1;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [3:0] b, input logic [31:0] m, input logic v,
                         input logic eh, input logic ew, input logic [31:0] er, input string req);
    ld_valid = v; ld_addr = a; ld_be = b; ld_mem_data = m;
    @(negedge clk);
    chk(ld_hit == eh, {req, " hit"}, {31'b0, ld_hit}, {31'b0, eh});
    chk(ld_wait == ew, {req, " wait"}, {31'b0, ld_wait}, {31'b0, ew});
    if (!ew) chk(ld_result == er, {req, " data"}, ld_result, er);
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(sb_empty == 1'b1, "R1 empty", {31'b0, sb_empty}, 32'h1);
    chk(sb_full == 1'b0, "R1 full", {31'b0, sb_full}, 32'h0);
    chk(st_stall == 1'b0, "R1 stall", {31'b0, st_stall}, 32'h0);
    chk(dr_valid == 3'b000, "R1 drain", {29'b0, dr_valid}, 32'h0);
    @(posedge clk); #1;

    // R2: fill all four entries with every port refusing
    rdy_mode = 0;
    push_store(32'h0000_1000, 32'h1111_0001, 4'hF, 2'b00);
    push_store(32'h0000_1004, 32'h2222_0002, 4'h3, 2'b01);
    push_store(32'h0000_1008, 32'h3333_0003, 4'hC, 2'b10);
    push_store(32'h0000_100C, 32'h4444_0004, 4'h1, 2'b00);
    @(negedge clk);
    chk(sb_full == 1'b1, "R2 full", {31'b0, sb_full}, 32'h1);
    chk(st_stall == 1'b1, "R2 stall", {31'b0, st_stall}, 32'h1);
    chk(dr_valid == 3'b001, "R4 head to cache", {29'b0, dr_valid}, 32'h1);
    held = dr_addr;
    @(posedge clk); #1;
    // R2: a store offered while stalled is dropped
    st_valid = 1'b1; st_addr = 32'hBAD0_0000; st_data = 32'hBADBAD00; st_be = 4'hF; st_tgt = 2'b01;
    repeat (3) @(posedge clk);
    #1 st_valid = 1'b0;
    @(negedge clk);
    // R10: head stays put while not accepted
    chk(dr_addr == held, "R10 head stable", dr_addr, held);
    chk(sb_full == 1'b1, "R2 still full", {31'b0, sb_full}, 32'h1);
    @(posedge clk); #1;
    rdy_mode = 1;
    wait_empty("R6 drained");
    chk(exp_q.size() == 0, "R2 dropped store absent", exp_q.size(), 32'h0);

    // R7 / R8: forwarding with drains held off
    rdy_mode = 0;
    push_store(32'h0000_0100, 32'h1122_3344, 4'hF, 2'b00);
    push_store(32'h0000_0200, 32'hAABB_CCDD, 4'h3, 2'b01);
    push_store(32'h0000_0100, 32'h5566_7788, 4'hC, 2'b10);
    do_load(32'h0000_0100, 4'hF, 32'h0, 1'b1, 1'b1, 1'b1, 32'h0, "R8 partial cover");
    do_load(32'h0000_0102, 4'hC, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 32'h5566_BEEF, "R7 newest match");
    do_load(32'h0000_0201, 4'h1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_CCDD, "R7 low half");
    do_load(32'h0000_0300, 4'hF, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'h1234_5678, "R7 miss");
    do_load(32'h0000_0100, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, "R7 no load");
    rdy_mode = 1;
    wait_empty("R6 drained after forward");
    do_load(32'h0000_0100, 4'hF, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 32'h0BAD_F00D, "R7 gone after drain");

    // R5 / R3: busy data RAM blocks the head and the cache store behind it
    bsy_mode = 0; bsy_val = 3'b010;
    push_store(32'h0000_0040, 32'hCAFE_0001, 4'hF, 2'b01);
    push_store(32'h0000_0044, 32'hCAFE_0002, 4'hF, 2'b00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dr_valid == 3'b000, "R5 busy holds head", {29'b0, dr_valid}, 32'h0);
    chk(sb_empty == 1'b0, "R3 younger waits", {31'b0, sb_empty}, 32'h0);
    @(posedge clk); #1;
    bsy_val = 3'b000;
    wait_empty("R5 drains when free");

    // R9: flush pulse
    rdy_mode = 0;
    push_store(32'h0000_0500, 32'h0000_0A0A, 4'hF, 2'b10);
    push_store(32'h0000_0504, 32'h0000_0B0B, 4'hF, 2'b00);
    flush = 1'b1;
    @(negedge clk);
    chk(st_stall == 1'b1, "R9 stall on flush", {31'b0, st_stall}, 32'h1);
    @(posedge clk); #1;
    flush = 1'b0;
    @(negedge clk);
    chk(st_stall == 1'b1, "R9 stall held", {31'b0, st_stall}, 32'h1);
    chk(sb_full == 1'b0, "R9 not full", {31'b0, sb_full}, 32'h0);
    @(posedge clk); #1;
    rdy_mode = 1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!sb_empty && n < 100);
      chk(sb_empty == 1'b1, "R9 empty", {31'b0, sb_empty}, 32'h1);
      chk(st_stall == 1'b0, "R9 stall released", {31'b0, st_stall}, 32'h0);
      @(posedge clk); #1;
    end

    // Mixed stream with pseudo-random ready and busy levels
    rdy_mode = 2; bsy_mode = 1;
    for (int k = 0; k < 24; k++)
      push_store(32'h0001_0000 + 32'(k * 4), 32'h5A5A_0000 ^ 32'(k * 32'h0101_0103),
                 4'(k % 15 + 1), 2'(k % 3));
    wait_empty("R6 mixed stream drained");
    chk(exp_q.size() == 0, "R3 all stores retired", exp_q.size(), 32'h0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule